// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a real-time clock peripheral that sits behind a simple byte-wide register bus made up of an address, write data, a write strobe, a read strobe and a registered read-data port. It holds a free-running 32-bit count of seconds, which advances by one on each single-cycle pulse of a one-per-second tick input. It also holds a 32-bit alarm compare value. The host moves both values one byte at a time, most significant byte first.

A time write is assembled in a staging register and reaches the counter only when its last byte arrives. A read of the top time byte captures the whole counter, so the three reads that follow return one coherent value even if ticks arrive between them. The alarm uses the same staged scheme. An alarm value of all ones means "disarmed"; there is no separate enable bit.

When the counter takes on a value equal to an armed alarm, the block sets a sticky status bit and drives an active-high interrupt level until software clears the bit by writing a one to it. The same event can also raise one-cycle wake and power-up request pulses, each gated by its own control bit.

Top module: `sec_rtc_top`

## Requirements
- R1: After reset, the counter is 0, the alarm is 0xFFFFFFFF, the status and control registers are 0, the outputs irq_o, wake_o and pwrup_o are low, and rdata_o is 0x00.
- R2: Each cycle in which tick_i is high and no time commit occurs, the counter increases by one. The count wraps from 0xFFFFFFFF to 0.
- R3: Time bytes are written with the most significant byte at 0x70 down to the least significant byte at 0x73. Writes to 0x70 to 0x72 only stage their byte. A write to 0x73 loads {staged bytes, written byte} into the counter, and this load takes priority over a tick in the same cycle.
- R4: A read strobe at 0x70 returns counter bits 31:24 and captures all 32 counter bits. Reads at 0x71, 0x72 and 0x73 return bits 23:16, 15:8 and 7:0 of that capture. Read data appears on rdata_o one cycle after the read strobe and holds until the next read.
- R5: Alarm bytes are written with the most significant byte at 0x74 down to the least significant byte at 0x77. Bytes written to 0x74 to 0x76 are staged, and the alarm changes only when 0x77 is written. Reads at 0x74 to 0x77 return the committed alarm bytes.
- R6: When the counter loads a new value, either by tick or by time commit, that equals the alarm, and the alarm is not 0xFFFFFFFF, bit 3 of the status register at 0x10 is set on that same clock edge. An alarm of 0xFFFFFFFF never sets it.
- R7: Writing 0x10 with bit 3 set clears the status bit, and writing it with bit 3 at 0 leaves the bit unchanged. A match in the same cycle as a clear leaves the bit set. The other bits of 0x10 read as 0.
- R8: irq_o is high exactly while status bit 3 is set.
- R9: Register 0x29 holds the power-up enable in bit 2 and the wake enable in bit 3, and its other bits read as 0. On the edge where R6 sets the status bit, pwrup_o or wake_o pulses high for one cycle if its enable bit is 1.
- R10: A read of 0x00 returns the VENDOR_ID parameter (default 0x5A). A read of 0x01 returns the REVISION parameter (default 0x41, which is at least 0x40). Writes to both addresses have no effect.
- R11: Reads of any unmapped address return 0x00, and writes to unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per byte |
| rd_en_i | input | 1 | Read strobe, one cycle per byte |
| rdata_o | output | 8 | Registered read data |
| tick_i | input | 1 | One-per-second tick pulse |
| irq_o | output | 1 | Alarm interrupt level |
| wake_o | output | 1 | Wake request pulse |
| pwrup_o | output | 1 | Power-up request pulse |

## Verification
The bound checker watches rules that must hold on every cycle:
- the counter either steps by one on a tick or stays still when there is neither a tick nor a commit;
- the read capture stays still unless 0x70 is read;
- a disarmed alarm never raises the interrupt;
- the interrupt level holds until a write-one-to-clear;
- wake and power-up pulses occur only together with the interrupt.

Some behaviours can only be shown by the bench scenarios:
- a coherent multi-byte read while ticks arrive;
- staged time and alarm commits;
- a commit winning over a tick;
- the wrap at all ones;
- a match that occurs at the same time as a clear;
- per-bit gating of the two request pulses;
- identifier values and unmapped-address behaviour.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam logic [7:0] ADDR_VENDOR = 8'h00;
  localparam logic [7:0] ADDR_REV    = 8'h01;
  localparam logic [7:0] ADDR_STS    = 8'h10;
  localparam logic [7:0] ADDR_CTL    = 8'h29;
  localparam int unsigned STS_ALM_BIT   = 3;
  localparam int unsigned CTL_PWRUP_BIT = 2;
  localparam int unsigned CTL_WAKE_BIT  = 3;
endpackage

// File: rtl/sec_rtc_stage.sv
// Multi-byte write assembly: lanes 0..NBYTES-2 staged, last lane commits.
module sec_rtc_stage #(
  parameter int unsigned NBYTES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [NBYTES-1:0]     sel_i,
  input  logic [7:0]            wdata_i,
  output logic                  commit_o,
  output logic [8*NBYTES-1:0]   value_o
);
  localparam int unsigned CW = 8 * NBYTES;

  for (genvar k = 0; k < NBYTES - 1; k++) begin : g_lane
    logic [7:0] hold_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                hold_q <= '0;
      else if (wr_i && sel_i[k])  hold_q <= wdata_i;
    end
    assign value_o[CW-1-8*k -: 8] = hold_q;
  end

  assign value_o[7:0] = wdata_i;
  assign commit_o     = wr_i & sel_i[NBYTES-1];
endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          step_o,
  output logic [CW-1:0] next_o
);
  logic [CW-1:0] cnt_q;

  // load wins over tick
  assign next_o = load_i ? load_val_i : cnt_q + CW'(1);
  assign step_o = tick_i | load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_o) cnt_q <= next_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          step_i,
  input  logic [CW-1:0] next_i,
  output logic [CW-1:0] alarm_o,
  output logic          match_o
);
  logic [CW-1:0] alarm_q;
  logic          armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     alarm_q <= '1;
    else if (load_i) alarm_q <= load_val_i;
  end

  // all-ones is the disarm sentinel
  assign armed   = ~&alarm_q;
  assign match_o = step_i & armed & (next_i == alarm_q);
  assign alarm_o = alarm_q;
endmodule

// File: rtl/sec_rtc_top.sv
module sec_rtc_top
  import sec_rtc_pkg::*;
#(
  parameter int unsigned NBYTES    = 4,
  parameter logic [7:0]  TIME_BASE = 8'h70,
  parameter logic [7:0]  ALM_BASE  = 8'h74,
  parameter logic [7:0]  VENDOR_ID = 8'h5A,
  parameter logic [7:0]  REVISION  = 8'h41
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  output logic [7:0] rdata_o,
  input  logic       tick_i,
  output logic       irq_o,
  output logic       wake_o,
  output logic       pwrup_o
);
  localparam int unsigned CW = 8 * NBYTES;

  logic [NBYTES-1:0] time_sel, alm_sel;
  logic              time_commit, alm_commit;
  logic [CW-1:0]     time_val, alm_val;
  logic [CW-1:0]     cnt_q, cnt_next, alarm_q, snap_q;
  logic              cnt_step, match;
  logic              sts_q, ctl_wake_q, ctl_pwrup_q, wake_q, pwrup_q;
  logic              sts_clr;
  logic [7:0]        rd_mux, rdata_q;

  for (genvar k = 0; k < NBYTES; k++) begin : g_dec
    assign time_sel[k] = (addr_i == TIME_BASE + 8'(k));
    assign alm_sel[k]  = (addr_i == ALM_BASE + 8'(k));
  end

  sec_rtc_stage #(.NBYTES(NBYTES)) u_time_stage (
    .clk_i, .rst_ni, .wr_i(wr_en_i), .sel_i(time_sel), .wdata_i,
    .commit_o(time_commit), .value_o(time_val)
  );

  sec_rtc_stage #(.NBYTES(NBYTES)) u_alm_stage (
    .clk_i, .rst_ni, .wr_i(wr_en_i), .sel_i(alm_sel), .wdata_i,
    .commit_o(alm_commit), .value_o(alm_val)
  );

  sec_rtc_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .load_i(time_commit), .load_val_i(time_val),
    .cnt_o(cnt_q), .step_o(cnt_step), .next_o(cnt_next)
  );

  sec_rtc_alarm #(.CW(CW)) u_alm (
    .clk_i, .rst_ni, .load_i(alm_commit), .load_val_i(alm_val),
    .step_i(cnt_step), .next_i(cnt_next), .alarm_o(alarm_q), .match_o(match)
  );

  assign sts_clr = wr_en_i && (addr_i == ADDR_STS) && wdata_i[STS_ALM_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q       <= 1'b0;
      ctl_wake_q  <= 1'b0;
      ctl_pwrup_q <= 1'b0;
      wake_q      <= 1'b0;
      pwrup_q     <= 1'b0;
    end else begin
      sts_q   <= match | (sts_q & ~sts_clr);   // set wins
      wake_q  <= match & ctl_wake_q;
      pwrup_q <= match & ctl_pwrup_q;
      if (wr_en_i && addr_i == ADDR_CTL) begin
        ctl_wake_q  <= wdata_i[CTL_WAKE_BIT];
        ctl_pwrup_q <= wdata_i[CTL_PWRUP_BIT];
      end
    end
  end

  // capture on top-byte read for coherent follow-up reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       snap_q <= '0;
    else if (rd_en_i && time_sel[0])   snap_q <= cnt_q;
  end

  function automatic logic [7:0] byte_of(input logic [CW-1:0] v, input int unsigned k);
    return v[CW-1-8*k -: 8];
  endfunction

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_VENDOR) rd_mux = VENDOR_ID;
    if (addr_i == ADDR_REV)    rd_mux = REVISION;
    if (addr_i == ADDR_STS)    rd_mux[STS_ALM_BIT] = sts_q;
    if (addr_i == ADDR_CTL) begin
      rd_mux[CTL_WAKE_BIT]  = ctl_wake_q;
      rd_mux[CTL_PWRUP_BIT] = ctl_pwrup_q;
    end
    for (int unsigned k = 0; k < NBYTES; k++) begin
      if (time_sel[k]) rd_mux = (k == 0) ? byte_of(cnt_q, 0) : byte_of(snap_q, k);
      if (alm_sel[k])  rd_mux = byte_of(alarm_q, k);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = sts_q;
  assign wake_o  = wake_q;
  assign pwrup_o = pwrup_q;
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int unsigned CW        = 32,
  parameter logic [7:0]  TIME_BASE = 8'h70
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [7:0]    addr_i,
  input logic [7:0]    wdata_i,
  input logic          tick_i,
  input logic          irq_o,
  input logic          wake_o,
  input logic          pwrup_o,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] alarm,
  input logic [CW-1:0] snap,
  input logic          time_commit
);
  assert_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !time_commit) |=> (cnt == $past(cnt) + CW'(1)));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !time_commit) |=> $stable(cnt));

  assert_snap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && addr_i == TIME_BASE) |=> $stable(snap));

  assert_sentinel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&alarm && !irq_o) |=> !irq_o);

  assert_irq_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr_en_i && addr_i == 8'h10 && wdata_i[3])) |=> irq_o);

  assert_wake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> irq_o);

  assert_pwrup_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrup_o |-> irq_o);
endmodule

bind sec_rtc_top sec_rtc_chk #(.CW(CW), .TIME_BASE(TIME_BASE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .tick_i(tick_i), .irq_o(irq_o),
  .wake_o(wake_o), .pwrup_o(pwrup_o), .cnt(cnt_q), .alarm(alarm_q),
  .snap(snap_q), .time_commit(time_commit)
);

// File: tb/sec_rtc_top_tb_top.sv
module sec_rtc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [7:0] rdata;
  logic       irq, wake, pwrup;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  sec_rtc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .tick_i(tick),
    .irq_o(irq), .wake_o(wake), .pwrup_o(pwrup)
  );

  // {op, addr, data/expected}; op 0=write 1=read-check 2=tick
  localparam int NV = 38;
  localparam logic [17:0] VEC [NV] = '{
    {2'd1, 8'h00, 8'h5A}, {2'd1, 8'h01, 8'h41}, {2'd0, 8'h00, 8'hFF}, {2'd1, 8'h00, 8'h5A}, // R10
    {2'd1, 8'h74, 8'hFF}, {2'd1, 8'h29, 8'h00},                                           // R1
    {2'd0, 8'h70, 8'h12}, {2'd0, 8'h71, 8'h34}, {2'd0, 8'h72, 8'h56}, {2'd1, 8'h70, 8'h00}, // R3
    {2'd0, 8'h73, 8'h78}, {2'd1, 8'h70, 8'h12}, {2'd2, 8'h00, 8'h00},                     // R3 R4
    {2'd1, 8'h71, 8'h34}, {2'd1, 8'h72, 8'h56}, {2'd1, 8'h73, 8'h78},                     // R4
    {2'd1, 8'h70, 8'h12}, {2'd1, 8'h73, 8'h79},                                           // R2
    {2'd0, 8'h29, 8'hFF}, {2'd1, 8'h29, 8'h0C},                                           // R9
    {2'd1, 8'h55, 8'h00}, {2'd0, 8'h55, 8'hAA}, {2'd1, 8'h55, 8'h00},                     // R11
    {2'd0, 8'h74, 8'h12}, {2'd0, 8'h75, 8'h34}, {2'd0, 8'h76, 8'h56}, {2'd1, 8'h77, 8'hFF}, // R5
    {2'd0, 8'h77, 8'h7B}, {2'd1, 8'h77, 8'h7B}, {2'd1, 8'h74, 8'h12},                     // R5
    {2'd1, 8'h10, 8'h00}, {2'd2, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h00}, {2'd1, 8'h10, 8'h08}, // R6
    {2'd0, 8'h10, 8'h00}, {2'd1, 8'h10, 8'h08}, {2'd0, 8'h10, 8'h08}, {2'd1, 8'h10, 8'h00}  // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] q);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; q = rdata;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_time(input logic [31:0] v);
    wr(8'h70, v[31:24]); wr(8'h71, v[23:16]); wr(8'h72, v[15:8]); wr(8'h73, v[7:0]);
  endtask

  task automatic set_alarm(input logic [31:0] v);
    wr(8'h74, v[31:24]); wr(8'h75, v[23:16]); wr(8'h76, v[15:8]); wr(8'h77, v[7:0]);
  endtask

  task automatic get_time(output logic [31:0] v);
    logic [7:0] b;
    rd(8'h70, b); v[31:24] = b;
    rd(8'h71, b); v[23:16] = b;
    rd(8'h72, b); v[15:8]  = b;
    rd(8'h73, b); v[7:0]   = b;
  endtask

  // tick and sample right after the edge that loads the alarm value
  task automatic tick_edge(input string req, input logic exp_wake, input logic exp_pwrup);
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #1;
    chk({req, " irq at match"}, 32'(irq), 32'd1);
    chk({req, " wake pulse"}, 32'(wake), 32'(exp_wake));
    chk({req, " pwrup pulse"}, 32'(pwrup), 32'(exp_pwrup));
    @(negedge clk); tick = 1'b0;
    @(posedge clk); #1;
    chk({req, " wake one cycle"}, 32'(wake), 32'd0);
    chk({req, " pwrup one cycle"}, 32'(pwrup), 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  q;
    logic [31:0] t;
    repeat (3) @(negedge clk);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 wake", 32'(wake), 32'd0);
    chk("R1 pwrup", 32'(pwrup), 32'd0);
    chk("R1 rdata", 32'(rdata), 32'd0);
    rst_n = 1'b1;
    get_time(t);
    chk("R1 counter", t, 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: wr(VEC[i][15:8], VEC[i][7:0]);
        2'd1: begin
          rd(VEC[i][15:8], q);
          chk($sformatf("vector %0d addr %0h", i, VEC[i][15:8]), 32'(q), 32'(VEC[i][7:0]));
        end
        default: tk();
      endcase
    end
    chk("R8 irq low after clear", 32'(irq), 32'd0);

    // R4 read data holds until the next read
    repeat (3) @(negedge clk);
    chk("R4 rdata hold", 32'(rdata), 32'd0);

    // R9 gating, alarm is 0x1234567B
    wr(8'h29, 8'h08); set_time(32'h1234_567A);
    tick_edge("R9 wake-only", 1'b1, 1'b0);
    wr(8'h10, 8'h08);
    chk("R8 irq cleared", 32'(irq), 32'd0);
    wr(8'h29, 8'h04); set_time(32'h1234_567A);
    tick_edge("R9 pwrup-only", 1'b0, 1'b1);
    wr(8'h10, 8'h08);
    wr(8'h29, 8'h00); set_time(32'h1234_567A);
    tick_edge("R9 none", 1'b0, 1'b0);
    wr(8'h10, 8'h08);

    // R7 match and clear in the same cycle: set wins
    set_time(32'h1234_567A);
    @(negedge clk); tick = 1'b1; addr = 8'h10; wdata = 8'h08; wr_en = 1'b1;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    chk("R7 set over clear", 32'(irq), 32'd1);
    wr(8'h10, 8'h08);

    // R3 commit wins over tick
    wr(8'h70, 8'h00); wr(8'h71, 8'h00); wr(8'h72, 8'h00);
    @(negedge clk); addr = 8'h73; wdata = 8'h05; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    get_time(t);
    chk("R3 commit over tick", t, 32'h0000_0005);

    // R2 wrap
    set_time(32'hFFFF_FFFF); tk(); get_time(t);
    chk("R2 wrap", t, 32'h0);

    // R6 sentinel never matches
    set_alarm(32'hFFFF_FFFF); set_time(32'hFFFF_FFFE); tk();
    chk("R6 sentinel no irq", 32'(irq), 32'd0);
    get_time(t);
    chk("R6 counter at ones", t, 32'hFFFF_FFFF);

    // R6 match via time commit
    set_alarm(32'h0000_0010); set_time(32'h0000_0010);
    chk("R6 commit match", 32'(irq), 32'd1);
    rd(8'h10, q);
    chk("R6 status bit 3", 32'(q), 32'h08);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule